// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block recovers 11-bit asynchronous frames from a single serial input line. A frame is a low start bit, eight data bits sent least significant bit first, a ninth bit and a high stop bit. The line is oversampled by a one-cycle enable pulse that arrives sixteen times per bit period. Each bit is resolved by a two-of-three vote over the samples nearest the bit center.

Halfway through the ninth bit the receiver decides whether to keep the frame. It keeps the frame only if the previous result has been consumed. In address mode it also requires the ninth bit to be 1. A kept frame updates the byte and ninth-bit outputs and raises a completion flag. The flag stays raised until software clears it. A refused frame leaves no trace. After the center of the stop bit the receiver waits for the next falling edge.

Top module: `ninebit_rx`

## Requirements
- R1: After reset `rx_done` is 0, `rx_data` is 8'h00 and `rx_bit9` is 0.
- R2: A frame starts only on a 1-to-0 transition of the synchronized `rx_line` while `rx_en` is 1. With `rx_en` at 0, a complete frame leaves all outputs unchanged.
- R3: Each bit value is the majority of the samples taken on oversampling ticks 7, 8 and 9 (of 0..15) after the bit boundary. A disturbance that covers only one of those samples does not alter the received value.
- R4: The first data bit after the start bit lands in `rx_data[0]` and the last in `rx_data[7]`.
- R5: If `rx_done` is 1 at the middle of the ninth bit, the frame is dropped: `rx_data` and `rx_bit9` keep their values and `rx_done` stays 1.
- R6: With `addr_mode` = 0 the ninth bit value does not affect acceptance. With `addr_mode` = 1 a frame whose ninth bit is 0 is dropped and the outputs are unchanged.
- R7: An accepted frame loads `rx_data` with the byte and `rx_bit9` with the ninth bit, and sets `rx_done`.
- R8: If the voted start bit is 1, the detection is abandoned as a false start and nothing is loaded. A following valid frame is still received.
- R9: `rx_done` holds 1 until `flag_clr` is 1 for a cycle. When `flag_clr` coincides with an acceptance, the data is loaded but `rx_done` stays 0.
- R10: After the middle of the stop bit the receiver returns to idle, so consecutive frames separated by idle line are each received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Permits new frame starts |
| addr_mode | input | 1 | 1 = accept only frames whose ninth bit is 1 |
| flag_clr | input | 1 | Clears the completion flag; wins over a set |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Completion flag |

## Verification
A bit counter or phase counter that slips shows up as a shifted or wrong byte in `rx_data` within the frame in progress. A broken acceptance decision shows up as a loaded byte or a raised `rx_done` where the outputs should have stayed put. This is visible one cycle after the ninth-bit center. A receiver stuck out of idle is exposed by the next frame not being received. Glitch and false-start stimulus expose a vote that uses fewer than three samples.

// File: rtl/nbrx_pkg.sv
package nbrx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/nbrx_sync.sv
module nbrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b1;
        else if (g == 0) chain_q[g] <= d_in;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/nbrx_sampler.sv
module nbrx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic line,
  output logic bit_stb,
  output logic bit_val
);
  localparam int PW = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [PW-1:0] S_FIRST = PW'(MID - 1);
  localparam logic [PW-1:0] S_LAST  = PW'(MID + 1);
  localparam logic [PW-1:0] P_MAX   = PW'(OSR - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [1:0]    votes_q, votes_d;

  always_comb begin
    phase_d = phase_q;
    votes_d = votes_q;
    if (restart) begin
      phase_d = '0;
      votes_d = '0;
    end else if (tick) begin
      phase_d = (phase_q == P_MAX) ? '0 : phase_q + 1'b1;
      if (phase_q >= S_FIRST && phase_q < S_LAST)
        votes_d = {votes_q[0], line};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      votes_q <= '0;
    end else begin
      phase_q <= phase_d;
      votes_q <= votes_d;
    end
  end

  assign bit_stb = tick && !restart && (phase_q == S_LAST);
  assign bit_val = (votes_q[1] & votes_q[0]) | (votes_q[1] & line) | (votes_q[0] & line);
endmodule

// File: rtl/nbrx_ctrl.sv
module nbrx_ctrl
  import nbrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              addr_mode,
  input  logic              flag_clr,
  input  logic              line_s,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              restart,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] IDX_NINTH = IW'(DATA_W + 1);
  localparam logic [IW-1:0] IDX_STOP  = IW'(DATA_W + 2);

  rx_state_e         state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b9_q, b9_d;
  logic              done_q, done_d;
  logic              prev_q;
  logic              fall, accept;

  assign fall    = prev_q & ~line_s;
  assign restart = (state_q == ST_IDLE) && rx_en && fall;
  assign accept  = bit_stb && (state_q == ST_BUSY) && (idx_q == IDX_NINTH)
                   && !done_q && (!addr_mode || bit_val);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    data_d  = data_q;
    b9_d    = b9_q;
    if (restart) begin
      state_d = ST_BUSY;
      idx_d   = '0;
    end else if (state_q == ST_BUSY && bit_stb) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == '0) begin
        if (bit_val) state_d = ST_IDLE;
      end else if (idx_q < IDX_NINTH) begin
        shift_d = {bit_val, shift_q[DATA_W-1:1]};
      end else if (idx_q == IDX_STOP) begin
        state_d = ST_IDLE;
      end
    end
    if (accept) begin
      data_d = shift_q;
      b9_d   = bit_val;
    end
    done_d = flag_clr ? 1'b0 : (accept | done_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      b9_q    <= 1'b0;
      done_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      data_q  <= data_d;
      b9_q    <= b9_d;
      done_q  <= done_d;
      prev_q  <= line_s;
    end
  end

  assign rx_data = data_q;
  assign rx_bit9 = b9_q;
  assign rx_done = done_q;

  assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !rx_done);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !flag_clr) |=> rx_done);
  assert_pending_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> ($stable(rx_data) && $stable(rx_bit9)));
  assert_addr_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_done) && $past(addr_mode)) |-> rx_bit9);
  assert_enable_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rx_en) |=> (state_q == ST_IDLE));
  assert_set_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(state_q == ST_BUSY));
endmodule

// File: rtl/ninebit_rx.sv
module ninebit_rx #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              addr_mode,
  input  logic              flag_clr,
  input  logic              tick16,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done
);
  logic line_s, restart, bit_stb, bit_val;

  nbrx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rx_line), .d_out(line_s)
  );

  nbrx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick16),
    .line(line_s), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  nbrx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .addr_mode(addr_mode),
    .flag_clr(flag_clr), .line_s(line_s), .bit_stb(bit_stb),
    .bit_val(bit_val), .restart(restart), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_done(rx_done)
  );
endmodule

// File: tb/sim_ninebit_rx.sv
module sim_ninebit_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = TICK_DIV * 16;
  localparam int NVEC       = 8;
  // {clr_before, addr_mode, bit9, data, exp_done, exp_bit9, exp_data}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'h55, 1'b0, 1'b1, 8'h3C},
    {1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 8'h81},
    {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'hFF},
    {1'b1, 1'b1, 1'b0, 8'h7E, 1'b0, 1'b1, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_line = 1'b1, rx_en = 1'b0, addr_mode = 1'b0, flag_clr = 1'b0, tick16 = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_done;
  int tick_cnt = 0;
  int n_cmp = 0, n_bad = 0;

  ninebit_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en),
    .addr_mode(addr_mode), .flag_clr(flag_clr), .tick16(tick16),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
    tick16   <= (tick_cnt == TICK_DIV-1);
  end

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input int glitch_bit);
    logic [10:0] bits;
    bits = {1'b1, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        @(negedge clk);
        rx_line = (i == glitch_bit && c >= 32 && c < 36) ? ~bits[i] : bits[i];
      end
    end
    @(negedge clk); rx_line = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 done", {8'h0, rx_done}, 9'h0);
    check("R1 data", {1'b0, rx_data}, 9'h0);
    check("R1 bit9", {8'h0, rx_bit9}, 9'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;

    // table: R4 R5 R6 R7 R10
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][20]) pulse_clr();
      addr_mode = VEC[v][19];
      send_frame(VEC[v][17:10], VEC[v][18], -1);
      check("R5/R6/R7 done", {8'h0, rx_done}, {8'h0, VEC[v][9]});
      check("R4/R7 data", {1'b0, rx_data}, {1'b0, VEC[v][7:0]});
      check("R7 bit9", {8'h0, rx_bit9}, {8'h0, VEC[v][8]});
    end

    // R2: disabled receiver ignores a frame
    pulse_clr();
    addr_mode = 1'b0;
    rx_en = 1'b0;
    send_frame(8'h5A, 1'b1, -1);
    check("R2 done", {8'h0, rx_done}, 9'h0);
    check("R2 data", {1'b0, rx_data}, 9'h0FF);
    rx_en = 1'b1;

    // R8: short low pulse is a false start, then a real frame
    repeat (4) @(negedge clk); rx_line = 1'b0;
    repeat (8) @(negedge clk); rx_line = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R8 no load", {rx_bit9, rx_data}, 9'h1FF);
    check("R8 done", {8'h0, rx_done}, 9'h0);
    send_frame(8'h96, 1'b0, -1);
    check("R8 recovery", {rx_bit9, rx_data}, 9'h096);

    // R3: one-sample glitch in data bit 3 (frame bit 4) and in the ninth bit
    pulse_clr();
    send_frame(8'h4B, 1'b1, 4);
    check("R3 data glitch", {rx_bit9, rx_data}, 9'h14B);
    pulse_clr();
    addr_mode = 1'b1;
    send_frame(8'h2D, 1'b1, 9);
    check("R3 ninth glitch", {rx_done, rx_data}, 9'h12D);
    addr_mode = 1'b0;

    // R9: clear held across an acceptance wins, data still loads
    pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    send_frame(8'hC3, 1'b0, -1);
    check("R9 data", {rx_bit9, rx_data}, 9'h0C3);
    check("R9 clr wins", {8'h0, rx_done}, 9'h0);
    @(negedge clk); flag_clr = 1'b0;
    send_frame(8'h11, 1'b1, -1);
    repeat (BIT_CLKS * 3) @(negedge clk);
    check("R9 sticky", {8'h0, rx_done}, 9'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule